// File: doc/BRIEF.md
# Page Access Permission and Protection-Key Checker

This block decides whether a memory access may use a page once a table walk has finished. From the combined attributes of the leaf, it builds the read/write/execute rights that the page grants. The walker supplies those attributes: user, read/write, no-execute, dirty, a reserved-bit flag and a 4-bit protection key. The rights are then reduced by the privilege rules, by write protection, by the supervisor-execute guard and by the rights that a protection-key register gives to the leaf's key. If the requested access is not in the surviving set, the block reports a denial with a page-fault error code.

A caller raises `chk_valid` for one cycle with all operands stable. The next cycle carries `res_valid` together with the verdict, the grant mask and the error code. Strobes may come in consecutive cycles, and each strobe gives its own result one cycle later.

A two-state machine controls the result side. `ST_IDLE` means no result is presented. `ST_HOLD` means a result is presented. The transition CAPTURE goes from `ST_IDLE` to `ST_HOLD` on a strobe. RECAPTURE stays in `ST_HOLD` on a strobe and loads a fresh result. RELEASE goes from `ST_HOLD` back to `ST_IDLE` when no strobe is present. A strobe in `ST_IDLE` always takes CAPTURE, and the absence of a strobe in `ST_IDLE` keeps the machine there.

Top module: `perm_check`

## Requirements
- R1: `res_valid` is high in exactly those cycles that follow a cycle where `chk_valid` was sampled high. The result fields belong to that strobe. After reset, `res_valid`, `res_allow`, `res_perm` and `res_err` are zero.
- R2: A user access (`is_user`=1) to a page whose user attribute is clear is denied, whatever the other attributes and keys are.
- R3: The write right is present when the page read/write attribute is set, or when the access is supervisor and `cfg_wp` is 0. Otherwise a write is denied.
- R4: The execute right is removed when `pg_nx`=1 and `cfg_nxe`=1. For a supervisor access, it is also removed when `cfg_smep`=1 and the page user attribute is set. A user fetch is not affected by `cfg_smep`.
- R5: Protection keys apply only when `cfg_long`=1. A user page uses `ukey_rights` when `cfg_ukey_en`=1. A supervisor page uses `skey_rights` when `cfg_skey_en`=1. In every other case the keys have no effect.
- R6: For key k, the bit at 2k of the selected register is access-disable and the bit at 2k+1 is write-disable. Access-disable removes read and write. Write-disable removes write only when the access is user or `cfg_wp`=1. Keys never remove execute.
- R7: When the key rights deny the requested access, error bits 5 and 0 are both set.
- R8: On a denial, `res_perm` is 0 and the error code has these bits: bit 0 is always set, bit 1 is set for a write, bit 2 is set for a user access, and bit 3 is set for a reserved-bit fault. All bits above 5 are zero. On a grant, `res_err` is 0.
- R9: Error bit 4 is set only for a fetch, and only when either `cfg_nxe` and `cfg_pae` are both 1 or `cfg_smep` is 1.
- R10: On a grant, the write bit of `res_perm` is cleared when `pg_dirty`=0, unless the access itself is a write.
- R11: `pg_rsvd`=1 denies the access first, with error bits 0 and 3, and never with bit 5.
- R12: The access kind is encoded as 0 for read, 1 for write and 2 for fetch, and 3 is treated as read. `res_perm` carries read on bit 0, write on bit 1 and execute on bit 2. A grant carries every right that the page, privilege and key rules leave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Check strobe, operands valid |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| is_user | input | 1 | Access made at user privilege |
| pg_user | input | 1 | Combined user attribute of the walk |
| pg_rw | input | 1 | Combined read/write attribute |
| pg_nx | input | 1 | Combined no-execute attribute |
| pg_dirty | input | 1 | Leaf dirty attribute |
| pg_rsvd | input | 1 | Walk found reserved bits set |
| pg_key | input | KEY_W | Protection key of the leaf |
| cfg_wp | input | 1 | Supervisor write protection enable |
| cfg_smep | input | 1 | Supervisor execute guard for user pages |
| cfg_nxe | input | 1 | No-execute enable |
| cfg_pae | input | 1 | Extended paging format active |
| cfg_long | input | 1 | Long mode active |
| cfg_ukey_en | input | 1 | User-page keys enable |
| cfg_skey_en | input | 1 | Supervisor-page keys enable |
| ukey_rights | input | RIGHTS_W | Key rights register for user pages |
| skey_rights | input | RIGHTS_W | Key rights register for supervisor pages |
| res_valid | output | 1 | Result presented this cycle |
| res_allow | output | 1 | Access granted |
| res_perm | output | 3 | Granted read/write/execute mask |
| res_err | output | ERR_W | Page-fault error code on denial |

## Verification
The hardest case to reach is a denial in which the key rights and the page rules interact. One example is a supervisor write-disable key, which denies only while `cfg_wp` is set. Another is an access-disable key on a fetch, which must still grant execute. Reaching either needs long mode, the right enable, the key register matching the page's user attribute and the key's bit pair set all at once. The stimulus therefore builds directed operand sets that place rights at chosen key positions in the register and leave the other keys with opposite rights. It then adds a long stream of pseudo-random operand sets, including back-to-back strobes, which a scoreboard checks against a bench-side model.

// File: rtl/perm_pkg.sv
package perm_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSV   = 2'd3
    } acc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } chk_st_e;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;

    localparam int EB_PROT  = 0;
    localparam int EB_WR    = 1;
    localparam int EB_USR   = 2;
    localparam int EB_RSVD  = 3;
    localparam int EB_FETCH = 4;
    localparam int EB_KEY   = 5;
    localparam int EB_COUNT = 6;

endpackage

// File: rtl/perm_base_rights.sv
module perm_base_rights
    import perm_pkg::*;
(
    input  logic       is_user,
    input  logic       pg_user,
    input  logic       pg_rw,
    input  logic       pg_nx,
    input  logic       cfg_wp,
    input  logic       cfg_smep,
    input  logic       cfg_nxe,
    output logic [2:0] base_perm,
    output logic       user_block
);

    logic nx_live;
    logic smep_hit;

    always_comb begin
        nx_live  = cfg_nxe & pg_nx;
        smep_hit = ~is_user & cfg_smep & pg_user;

        base_perm         = '0;
        base_perm[PERM_R] = 1'b1;
        base_perm[PERM_W] = pg_rw | (~is_user & ~cfg_wp);
        base_perm[PERM_X] = ~nx_live & ~smep_hit;

        user_block = is_user & ~pg_user;
    end

endmodule

// File: rtl/perm_key_rights.sv
module perm_key_rights
    import perm_pkg::*;
#(
    parameter int KEY_W   = 4,
    parameter bit KEYS_EN = 1'b1,
    localparam int RIGHTS_W = 2 * (1 << KEY_W)
) (
    input  logic                is_user,
    input  logic                pg_user,
    input  logic [KEY_W-1:0]    pg_key,
    input  logic                cfg_wp,
    input  logic                cfg_long,
    input  logic                cfg_ukey_en,
    input  logic                cfg_skey_en,
    input  logic [RIGHTS_W-1:0] ukey_rights,
    input  logic [RIGHTS_W-1:0] skey_rights,
    output logic [2:0]          key_perm
);

    generate
        if (KEYS_EN) begin : g_keys
            logic [RIGHTS_W-1:0] sel_rights;
            logic                ad_bit;
            logic                wd_bit;

            always_comb begin
                sel_rights = '0;
                if (cfg_long) begin
                    if (pg_user) begin
                        if (cfg_ukey_en) sel_rights = ukey_rights;
                    end else begin
                        if (cfg_skey_en) sel_rights = skey_rights;
                    end
                end
                ad_bit = sel_rights[{pg_key, 1'b0}];
                wd_bit = sel_rights[{pg_key, 1'b1}];

                key_perm = 3'b111;
                if (ad_bit) begin
                    key_perm[PERM_R] = 1'b0;
                    key_perm[PERM_W] = 1'b0;
                end else if (wd_bit && (is_user || cfg_wp)) begin
                    key_perm[PERM_W] = 1'b0;
                end
            end
        end else begin : g_nokeys
            logic unused_in;
            assign unused_in = ^{is_user, pg_user, pg_key, cfg_wp, cfg_long,
                                 cfg_ukey_en, cfg_skey_en, ukey_rights, skey_rights};
            assign key_perm  = 3'b111;
        end
    endgenerate

endmodule

// File: rtl/perm_err_build.sv
module perm_err_build
    import perm_pkg::*;
#(
    parameter int ERR_W = 16
) (
    input  logic [1:0]       acc_kind,
    input  logic             is_user,
    input  logic             rsvd_fault,
    input  logic             key_fault,
    input  logic             cfg_nxe,
    input  logic             cfg_pae,
    input  logic             cfg_smep,
    output logic [ERR_W-1:0] err_code
);

    logic fetch_tag;

    always_comb begin
        fetch_tag = (acc_kind == ACC_FETCH) & ((cfg_nxe & cfg_pae) | cfg_smep);

        err_code            = '0;
        err_code[EB_PROT]   = 1'b1;
        err_code[EB_WR]     = (acc_kind == ACC_WRITE);
        err_code[EB_USR]    = is_user;
        err_code[EB_RSVD]   = rsvd_fault;
        err_code[EB_FETCH]  = fetch_tag;
        err_code[EB_KEY]    = key_fault & ~rsvd_fault;
    end

endmodule

// File: rtl/perm_check.sv
module perm_check
    import perm_pkg::*;
#(
    parameter int KEY_W   = 4,
    parameter int ERR_W   = 16,
    parameter bit KEYS_EN = 1'b1,
    localparam int RIGHTS_W = 2 * (1 << KEY_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chk_valid,
    input  logic [1:0]          acc_kind,
    input  logic                is_user,
    input  logic                pg_user,
    input  logic                pg_rw,
    input  logic                pg_nx,
    input  logic                pg_dirty,
    input  logic                pg_rsvd,
    input  logic [KEY_W-1:0]    pg_key,
    input  logic                cfg_wp,
    input  logic                cfg_smep,
    input  logic                cfg_nxe,
    input  logic                cfg_pae,
    input  logic                cfg_long,
    input  logic                cfg_ukey_en,
    input  logic                cfg_skey_en,
    input  logic [RIGHTS_W-1:0] ukey_rights,
    input  logic [RIGHTS_W-1:0] skey_rights,
    output logic                res_valid,
    output logic                res_allow,
    output logic [2:0]          res_perm,
    output logic [ERR_W-1:0]    res_err
);

    chk_st_e state_q, state_d;

    logic [2:0]       base_perm;
    logic             user_block;
    logic [2:0]       key_perm;
    logic [2:0]       want;
    logic [2:0]       merged;
    logic             key_deny;
    logic             base_deny;
    logic             deny;
    logic [2:0]       grant;
    logic [ERR_W-1:0] err_raw;

    perm_base_rights u_base (
        .is_user    (is_user),
        .pg_user    (pg_user),
        .pg_rw      (pg_rw),
        .pg_nx      (pg_nx),
        .cfg_wp     (cfg_wp),
        .cfg_smep   (cfg_smep),
        .cfg_nxe    (cfg_nxe),
        .base_perm  (base_perm),
        .user_block (user_block)
    );

    perm_key_rights #(.KEY_W(KEY_W), .KEYS_EN(KEYS_EN)) u_key (
        .is_user     (is_user),
        .pg_user     (pg_user),
        .pg_key      (pg_key),
        .cfg_wp      (cfg_wp),
        .cfg_long    (cfg_long),
        .cfg_ukey_en (cfg_ukey_en),
        .cfg_skey_en (cfg_skey_en),
        .ukey_rights (ukey_rights),
        .skey_rights (skey_rights),
        .key_perm    (key_perm)
    );

    // Decode the request and merge the two rights sets
    always_comb begin
        unique case (acc_kind)
            ACC_WRITE: want = 3'b010;
            ACC_FETCH: want = 3'b100;
            default:   want = 3'b001;
        endcase
        merged    = base_perm & key_perm;
        key_deny  = ~pg_rsvd & ~user_block & (|(want & ~key_perm));
        base_deny = ~(|(want & merged));
        deny      = pg_rsvd | user_block | base_deny;
        grant     = merged;
        if (!pg_dirty && acc_kind != ACC_WRITE) grant[PERM_W] = 1'b0;
        if (deny) grant = '0;
    end

    perm_err_build #(.ERR_W(ERR_W)) u_err (
        .acc_kind   (acc_kind),
        .is_user    (is_user),
        .rsvd_fault (pg_rsvd),
        .key_fault  (key_deny),
        .cfg_nxe    (cfg_nxe),
        .cfg_pae    (cfg_pae),
        .cfg_smep   (cfg_smep),
        .err_code   (err_raw)
    );

    // Next-state logic: CAPTURE, RECAPTURE, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (chk_valid) state_d = ST_HOLD;
            ST_HOLD: if (!chk_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result registers, loaded on every strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_allow <= 1'b0;
            res_perm  <= '0;
            res_err   <= '0;
        end else if (chk_valid) begin
            res_allow <= ~deny;
            res_perm  <= grant;
            res_err   <= deny ? err_raw : '0;
        end
    end

    assign res_valid = (state_q == ST_HOLD);

    // R1
    strobe_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> res_valid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !res_valid);

    // R8
    grant_err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_allow) |-> (res_err == '0));

    // R8
    deny_mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_allow) |-> (res_perm == 3'b000 && res_err[EB_PROT]));

    // R7
    key_bit_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err[EB_KEY]) |-> ($past(cfg_long) && !$past(pg_rsvd)));

    // R10
    dirty_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_perm[PERM_W]) |-> ($past(pg_dirty) || $past(acc_kind) == ACC_WRITE));

    // R2
    user_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(is_user) && !$past(pg_user)) |-> !res_allow);

    // R9
    fetch_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err[EB_FETCH]) |-> ($past(acc_kind) == ACC_FETCH));

endmodule

// File: tb/test_perm_check.sv
module test_perm_check;

    localparam int KEY_W = 4;
    localparam int ERR_W = 16;
    localparam int RW    = 2 * (1 << KEY_W);

    typedef struct packed {
        logic [1:0]    kind;
        logic          usr;
        logic          pu;
        logic          prw;
        logic          pnx;
        logic          pd;
        logic          rsvd;
        logic [3:0]    key;
        logic          wp;
        logic          smep;
        logic          nxe;
        logic          pae;
        logic          lng;
        logic          uen;
        logic          sen;
        logic [RW-1:0] ur;
        logic [RW-1:0] sr;
    } stim_t;

    typedef struct packed {
        logic             allow;
        logic [2:0]       perm;
        logic [ERR_W-1:0] err;
        logic [7:0]       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chk_valid = 1'b0;
    logic [1:0] acc_kind = '0;
    logic is_user = 0, pg_user = 0, pg_rw = 0, pg_nx = 0, pg_dirty = 0, pg_rsvd = 0;
    logic [KEY_W-1:0] pg_key = '0;
    logic cfg_wp = 0, cfg_smep = 0, cfg_nxe = 0, cfg_pae = 0, cfg_long = 0;
    logic cfg_ukey_en = 0, cfg_skey_en = 0;
    logic [RW-1:0] ukey_rights = '0, skey_rights = '0;
    logic res_valid, res_allow;
    logic [2:0] res_perm;
    logic [ERR_W-1:0] res_err;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    perm_check #(.KEY_W(KEY_W), .ERR_W(ERR_W)) i_perm_check (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .acc_kind(acc_kind),
        .is_user(is_user), .pg_user(pg_user), .pg_rw(pg_rw), .pg_nx(pg_nx),
        .pg_dirty(pg_dirty), .pg_rsvd(pg_rsvd), .pg_key(pg_key),
        .cfg_wp(cfg_wp), .cfg_smep(cfg_smep), .cfg_nxe(cfg_nxe), .cfg_pae(cfg_pae),
        .cfg_long(cfg_long), .cfg_ukey_en(cfg_ukey_en), .cfg_skey_en(cfg_skey_en),
        .ukey_rights(ukey_rights), .skey_rights(skey_rights),
        .res_valid(res_valid), .res_allow(res_allow), .res_perm(res_perm), .res_err(res_err)
    );

    // Bench model built from the requirement text
    function automatic exp_t model(stim_t s, logic [7:0] tag);
        exp_t e;
        logic rd, wr, ex, krd, kwr, kdeny, ok;
        logic [RW-1:0] rights;
        e = '0;
        e.tag = tag;
        e.err[1] = (s.kind == 2'd1);
        e.err[2] = s.usr;
        e.err[4] = (s.kind == 2'd2) && ((s.nxe && s.pae) || s.smep);
        e.err[0] = 1'b1;
        if (s.rsvd) begin
            e.err[3] = 1'b1;
            return e;
        end
        if (s.usr && !s.pu) return e;
        rd = 1'b1;
        wr = s.prw || (!s.usr && !s.wp);
        ex = !(s.nxe && s.pnx) && !( !s.usr && s.smep && s.pu);
        rights = '0;
        if (s.lng) rights = s.pu ? (s.uen ? s.ur : '0) : (s.sen ? s.sr : '0);
        krd = 1'b1; kwr = 1'b1;
        if (rights[2*s.key]) begin krd = 0; kwr = 0; end
        else if (rights[2*s.key+1] && (s.usr || s.wp)) kwr = 0;
        kdeny = (s.kind == 2'd1) ? !kwr : (s.kind == 2'd2) ? 1'b0 : !krd;
        if (kdeny) begin
            e.err[5] = 1'b1;
            return e;
        end
        rd = rd & krd; wr = wr & kwr;
        ok = (s.kind == 2'd1) ? wr : (s.kind == 2'd2) ? ex : rd;
        if (!ok) return e;
        if (!s.pd && s.kind != 2'd1) wr = 1'b0;
        e.allow = 1'b1;
        e.perm = {ex, wr, rd};
        e.err = '0;
        return e;
    endfunction

    function automatic stim_t plain();
        stim_t s = '0;
        s.prw = 1; s.pd = 1; s.pae = 1; s.nxe = 1;
        return s;
    endfunction

    task automatic apply(stim_t s, logic [7:0] tag);
        @(negedge clk);
        chk_valid = 1'b1;
        acc_kind = s.kind; is_user = s.usr; pg_user = s.pu; pg_rw = s.prw;
        pg_nx = s.pnx; pg_dirty = s.pd; pg_rsvd = s.rsvd; pg_key = s.key;
        cfg_wp = s.wp; cfg_smep = s.smep; cfg_nxe = s.nxe; cfg_pae = s.pae;
        cfg_long = s.lng; cfg_ukey_en = s.uen; cfg_skey_en = s.sen;
        ukey_rights = s.ur; skey_rights = s.sr;
        sb.push_back(model(s, tag));
    endtask

    task automatic gap();
        @(negedge clk);
        chk_valid = 1'b0;
    endtask

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Monitor: timing of res_valid and scoreboard compare
    initial begin
        logic v;
        exp_t e;
        forever begin
            @(posedge clk);
            v = chk_valid && rst_n;
            #5;
            if (rst_n) begin
                check(res_valid == v, "R1 valid timing", {31'd0, res_valid}, {31'd0, v});
                if (res_valid) begin
                    if (sb.size() == 0) begin
                        check(0, "R1 unexpected result", 32'd1, 32'd0);
                    end else begin
                        e = sb.pop_front();
                        check(res_allow == e.allow, $sformatf("R12 allow tag %0d", e.tag),
                              {31'd0, res_allow}, {31'd0, e.allow});
                        check(res_perm == e.perm, $sformatf("R12 perm tag %0d", e.tag),
                              {29'd0, res_perm}, {29'd0, e.perm});
                        check(res_err == e.err, $sformatf("R8 err tag %0d", e.tag),
                              {16'd0, res_err}, {16'd0, e.err});
                    end
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        stim_t s;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(res_valid == 0 && res_allow == 0 && res_perm == 0 && res_err == 0,
              "R1 reset", {res_valid, res_allow, res_perm, res_err[9:0]}, 32'd0);
        rst_n = 1'b1;
        gap();

        // R12 supervisor read, all rights granted
        s = plain(); apply(s, 1); gap();
        // R12 access code 3 acts as read
        s = plain(); s.kind = 2'd3; apply(s, 2); gap();
        // R2 user read of supervisor page -> err 0x05
        s = plain(); s.usr = 1; apply(s, 3); gap();
        // R3 supervisor write, rw clear, wp off -> allowed
        s = plain(); s.kind = 1; s.prw = 0; apply(s, 4);
        // R3 same with wp on -> err 0x03 (back-to-back strobe, R1)
        s.wp = 1; apply(s, 5);
        // R3 user write read-only user page
        s = plain(); s.kind = 1; s.usr = 1; s.pu = 1; s.prw = 0; apply(s, 6); gap();
        // R4 R9 fetch of no-execute page, nxe and pae on -> 0x11
        s = plain(); s.kind = 2; s.pnx = 1; apply(s, 7);
        // R9 pae off, no smep -> 0x01
        s.pae = 0; apply(s, 8);
        // R4 no-execute ignored with nxe off
        s = plain(); s.kind = 2; s.pnx = 1; s.nxe = 0; apply(s, 9); gap();
        // R4 SMEP supervisor fetch of user page -> deny, R9 bit 4 from smep
        s = plain(); s.kind = 2; s.pu = 1; s.smep = 1; s.nxe = 0; apply(s, 10);
        // R4 user fetch unaffected by SMEP
        s.usr = 1; apply(s, 11); gap();
        // R6 R7 access-disable on key 5 for user read -> 0x25
        s = plain(); s.usr = 1; s.pu = 1; s.lng = 1; s.uen = 1; s.key = 4'd5;
        s.ur = 32'h0000_0400; s.sr = 32'hFFFF_FFFF; apply(s, 12);
        // R6 write-disable key 5 user write -> 0x27
        s.ur = 32'hAAAA_A955 & ~32'h0000_0400 | 32'h0000_0800; s.kind = 1; apply(s, 13);
        // R6 write-disable leaves read, mask drops W
        s.kind = 0; apply(s, 14);
        // R5 keys off outside long mode
        s.lng = 0; s.kind = 1; apply(s, 15);
        // R5 user keys disabled
        s.lng = 1; s.uen = 0; apply(s, 16); gap();
        // R5 R6 supervisor page uses supervisor register; WD with wp off allowed
        s = plain(); s.kind = 1; s.lng = 1; s.sen = 1; s.key = 4'd15;
        s.sr = 32'h8000_0000; s.ur = 32'hFFFF_FFFF; apply(s, 17);
        // R6 same with wp on -> denied with key bit
        s.wp = 1; apply(s, 18);
        // R5 supervisor keys disabled
        s.sen = 0; apply(s, 19); gap();
        // R6 access-disable never removes execute
        s = plain(); s.kind = 2; s.usr = 1; s.pu = 1; s.lng = 1; s.uen = 1;
        s.key = 4'd0; s.ur = 32'h0000_0001; apply(s, 20);
        // R10 dirty clear read: no W in mask
        s = plain(); s.pd = 0; apply(s, 21);
        // R10 dirty clear write: W kept
        s.kind = 1; apply(s, 22); gap();
        // R11 reserved bits take precedence over key denial -> 0x09 family
        s = plain(); s.rsvd = 1; s.usr = 1; s.pu = 1; s.lng = 1; s.uen = 1;
        s.ur = 32'hFFFF_FFFF; apply(s, 23);
        s.kind = 1; apply(s, 24); gap();

        // Pseudo-random stream with occasional gaps
        for (int i = 0; i < 600; i++) begin
            s.kind = 2'($urandom_range(0, 3));
            s.usr = 1'($urandom); s.pu = 1'($urandom); s.prw = 1'($urandom);
            s.pnx = 1'($urandom); s.pd = 1'($urandom);
            s.rsvd = ($urandom_range(0, 9) == 0);
            s.key = 4'($urandom); s.wp = 1'($urandom); s.smep = 1'($urandom);
            s.nxe = 1'($urandom); s.pae = 1'($urandom); s.lng = 1'($urandom);
            s.uen = 1'($urandom); s.sen = 1'($urandom);
            s.ur = $urandom; s.sr = $urandom;
            apply(s, 8'(100 + (i % 150)));
            if ($urandom_range(0, 3) == 0) gap();
        end
        gap();
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R1 all results seen", sb.size(), 32'd0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule